// File: doc/BRIEF.md
# Parallel NOR Flash Command Decoder

This block watches the bus write cycles aimed at a parallel NOR flash array and turns them into commands according to the usual two-cycle unlock protocol. Each write brings a word address, which is already scaled for the bus width, and a data byte. The decoder records how far a command sequence has advanced. It tells the read path which source to return: array data, identification words, status, or the CFI query table. When a program or erase command is accepted, it raises a one-cycle strobe for the engine that does the work.

The two unlock addresses arrive as inputs, so a single instance can serve parts that use different unlock maps. An external timing engine does the actual erase. It reports through `erase_open`, which is high while further sector addresses may still be queued, and through `erase_done`. The decoder also drives the word that an identification read returns.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset, `rd_mode` is 0 (array), and `prog_stb`, `chip_erase_stb` and `sect_erase_stb` are low.
- R2: A command is accepted only after 0xAA at unlock address 0, then 0x55 at unlock address 1, then the command byte at unlock address 0. Only address bits [10:0] are compared. Any mismatching cycle returns the block to array mode.
- R3: Command 0x90 selects identification mode (`rd_mode` = 1). In that mode, `id_q` returns the following: `id0` for word index 0x00, `id1` for index 0x01, 0 for index 0x02, `id2` for index 0x0E and `id3` for index 0x0F. For index 0x0E or 0x0F, if the selected ID equals 0x00FF, `arr_q` is returned instead. Every other index also returns `arr_q`.
- R4: Command 0xA0 sets `rd_mode` = 2 while a program is pending. The next write then pulses `prog_stb` for one cycle. With that pulse, `prog_addr` holds the write address and `prog_data` holds `wr_data & arr_q[7:0]`. The block then returns to array mode.
- R5: After 0x80 and a second 0xAA/0x55 unlock pair, 0x10 at unlock address 0 pulses `chip_erase_stb`. 0x30 at any address pulses `sect_erase_stb`, with `sect_addr` holding that address. Both set `rd_mode` = 2. Any other byte, or 0x10 at another address, returns the block to array mode with no strobe.
- R6: During a sector erase with `erase_open` high, another 0x30 pulses `sect_erase_stb` again, and any other byte returns the block to array mode. With `erase_open` low, writes have no effect. `erase_done` ends either erase.
- R7: Command 0x20 enters bypass mode. In bypass mode a command byte is taken at any address without unlock cycles. A finished program returns to the bypass command state. In identification mode, 0x00 leaves bypass mode.
- R8: Writing 0x98 at word 0x55 from array mode enters CFI mode (`rd_mode` = 3). Any later write returns the block to array mode.
- R9: Writing 0x98 at word 0x55 from identification mode enters CFI mode, and a later 0xF0 returns the block to identification mode.
- R10: 0xF0 returns the block to array mode and clears bypass mode. It has no such effect while a program is pending, where it is taken as the program data, or while an erase runs.
- R11: At most one strobe is high in any cycle. With no write and no `erase_done`, `rd_mode` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write cycle |
| wr_addr | input | AW | Word address of the write |
| wr_data | input | 8 | Write data byte |
| unlock_a0 | input | 11 | First unlock address |
| unlock_a1 | input | 11 | Second unlock address |
| erase_open | input | 1 | Extra sector addresses may still be queued |
| erase_done | input | 1 | Erase engine finished |
| rd_idx | input | 8 | Low byte of the read word index |
| arr_q | input | 16 | Array word at the presented address |
| id0 | input | 16 | Manufacturer ID |
| id1 | input | 16 | Device ID |
| id2 | input | 16 | Extended ID 1 |
| id3 | input | 16 | Extended ID 2 |
| rd_mode | output | 2 | 0 array, 1 identification, 2 status, 3 CFI |
| id_q | output | 16 | Identification read word |
| prog_stb | output | 1 | Program request |
| prog_addr | output | AW | Program address |
| prog_data | output | 8 | Value to store (old AND new) |
| chip_erase_stb | output | 1 | Chip erase request |
| sect_erase_stb | output | 1 | Sector erase request |
| sect_addr | output | AW | Sector erase address |

## Verification
Several write patterns drive the decoder. A fully unlocked sequence with high address bits set shows that only the low 11 bits are compared. A sequence with a wrong second unlock address separates a correct reset from a decoder that keeps going. A 0xF0 sent while a program is pending, while an erase runs, and from CFI mode entered via identification shows which states honour the reset and where the block returns to. Bypass-mode sequences sent at arbitrary addresses, with and without the 0x00 exit, separate a persistent bypass flag from one that is lost after a single command.

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq #(
  parameter int AW = 16,
  parameter int UW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [UW-1:0] unlock_a0,
  input  logic [UW-1:0] unlock_a1,
  input  logic          erase_open,
  input  logic          erase_done,
  input  logic [7:0]    rd_idx,
  input  logic [15:0]   arr_q,
  input  logic [15:0]   id0,
  input  logic [15:0]   id1,
  input  logic [15:0]   id2,
  input  logic [15:0]   id3,
  output logic [1:0]    rd_mode,
  output logic [15:0]   id_q,
  output logic          prog_stb,
  output logic [AW-1:0] prog_addr,
  output logic [7:0]    prog_data,
  output logic          chip_erase_stb,
  output logic          sect_erase_stb,
  output logic [AW-1:0] sect_addr
);

  localparam logic [UW-1:0] CFI_WORD = UW'(8'h55);

  typedef enum logic [3:0] {
    ST_READ, ST_UNL1, ST_CMD, ST_AUTO, ST_PROG, ST_EU0, ST_EU1,
    ST_ECMD, ST_CHIP, ST_SECT, ST_CFI, ST_CFIA
  } st_t;

  st_t  st, st_n;
  logic byp, byp_n, p_n, c_n, s_n;

  wire [UW-1:0] wa   = wr_addr[UW-1:0];
  wire          hit0 = (wa == unlock_a0);
  wire          hit1 = (wa == unlock_a1);
  wire          cfik = (wa == CFI_WORD) && (wr_data == 8'h98);
  wire          busy = (st == ST_PROG) || (st == ST_CHIP) || (st == ST_SECT);

  always_comb begin
    st_n  = st;
    byp_n = byp;
    p_n   = 1'b0;
    c_n   = 1'b0;
    s_n   = 1'b0;
    if (erase_done && (st == ST_CHIP || st == ST_SECT)) begin
      st_n = byp ? ST_CMD : ST_READ;
    end else if (wr_en) begin
      if (wr_data == 8'hF0 && !busy) begin
        if (st == ST_CFIA) st_n = ST_AUTO;
        else begin st_n = ST_READ; byp_n = 1'b0; end
      end else begin
        st_n  = ST_READ;
        byp_n = 1'b0;
        case (st)
          ST_READ, ST_EU0: begin
            if (cfik) st_n = ST_CFI;
            else if (hit0 && wr_data == 8'hAA) begin
              st_n  = (st == ST_READ) ? ST_UNL1 : ST_EU1;
              byp_n = byp;
            end
          end
          ST_UNL1, ST_EU1: begin
            if (hit1 && wr_data == 8'h55) begin
              st_n  = (st == ST_UNL1) ? ST_CMD : ST_ECMD;
              byp_n = byp;
            end
          end
          ST_CMD: begin
            if (byp || hit0) begin
              byp_n = byp;
              case (wr_data)
                8'h20:   begin st_n = ST_CMD; byp_n = 1'b1; end
                8'h80:   st_n = ST_EU0;
                8'h90:   st_n = ST_AUTO;
                8'hA0:   st_n = ST_PROG;
                default: begin st_n = ST_READ; byp_n = 1'b0; end
              endcase
            end
          end
          ST_AUTO: begin
            if (!(byp && wr_data == 8'h00) && cfik) begin
              st_n  = ST_CFIA;
              byp_n = byp;
            end
          end
          ST_PROG: begin
            p_n   = 1'b1;
            st_n  = byp ? ST_CMD : ST_READ;
            byp_n = byp;
          end
          ST_ECMD: begin
            if (wr_data == 8'h10 && hit0) begin
              st_n = ST_CHIP; c_n = 1'b1; byp_n = byp;
            end else if (wr_data == 8'h30) begin
              st_n = ST_SECT; s_n = 1'b1; byp_n = byp;
            end
          end
          ST_CHIP: begin
            st_n  = st;
            byp_n = byp;
          end
          ST_SECT: begin
            st_n  = st;
            byp_n = byp;
            if (erase_open) begin
              if (wr_data == 8'h30) s_n = 1'b1;
              else begin st_n = ST_READ; byp_n = 1'b0; end
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st             <= ST_READ;
      byp            <= 1'b0;
      prog_stb       <= 1'b0;
      chip_erase_stb <= 1'b0;
      sect_erase_stb <= 1'b0;
      prog_addr      <= '0;
      prog_data      <= '0;
      sect_addr      <= '0;
    end else begin
      st             <= st_n;
      byp            <= byp_n;
      prog_stb       <= p_n;
      chip_erase_stb <= c_n;
      sect_erase_stb <= s_n;
      if (p_n) begin
        prog_addr <= wr_addr;
        prog_data <= wr_data & arr_q[7:0];
      end
      if (s_n) sect_addr <= wr_addr;
    end
  end

  always_comb begin
    case (st)
      ST_AUTO:                   rd_mode = 2'd1;
      ST_PROG, ST_CHIP, ST_SECT: rd_mode = 2'd2;
      ST_CFI, ST_CFIA:           rd_mode = 2'd3;
      default:                   rd_mode = 2'd0;
    endcase
  end

  always_comb begin
    case (rd_idx)
      8'h00:   id_q = id0;
      8'h01:   id_q = id1;
      8'h02:   id_q = 16'h0000;
      8'h0E:   id_q = (id2 == 16'h00FF) ? arr_q : id2;
      8'h0F:   id_q = (id3 == 16'h00FF) ? arr_q : id3;
      default: id_q = arr_q;
    endcase
  end

  // R11
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prog_stb, chip_erase_stb, sect_erase_stb}));

  // R4
  prog_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_stb |-> rd_mode == 2'd0);

  // R5
  erase_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_erase_stb || sect_erase_stb) |-> rd_mode == 2'd2);

  // R8
  cfi_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_mode == 2'd3 && wr_en) |=> rd_mode != 2'd3);

  // R11
  quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !erase_done) |=> $stable(rd_mode));

endmodule

// File: tb/tb_nor_cmd_seq.sv
module tb_nor_cmd_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [10:0] unlock_a0 = 11'h555;
  logic [10:0] unlock_a1 = 11'h2AA;
  logic        erase_open = 1'b0;
  logic        erase_done = 1'b0;
  logic [7:0]  rd_idx = '0;
  logic [15:0] arr_q = 16'h5A3C;
  logic [15:0] id0 = 16'h0001, id1 = 16'h227E, id2 = 16'h2210, id3 = 16'h00FF;
  logic [1:0]  rd_mode;
  logic [15:0] id_q;
  logic        prog_stb, chip_erase_stb, sect_erase_stb;
  logic [15:0] prog_addr, sect_addr;
  logic [7:0]  prog_data;

  int checks = 0;
  int errors = 0;

  nor_cmd_seq dut (.*);

  always #5 clk = ~clk;

  // {addr, data, mode, {prog,chip,sect}}
  localparam logic [28:0] VEC [20] = '{
    {16'h0555, 8'hAA, 2'd0, 3'b000},
    {16'h02AA, 8'h55, 2'd0, 3'b000},
    {16'h0555, 8'h90, 2'd1, 3'b000},  // R3
    {16'h0055, 8'h98, 2'd3, 3'b000},  // R9
    {16'h0000, 8'hF0, 2'd1, 3'b000},  // R9
    {16'h0000, 8'hF0, 2'd0, 3'b000},  // R10
    {16'h0055, 8'h98, 2'd3, 3'b000},  // R8
    {16'h0123, 8'h00, 2'd0, 3'b000},  // R8
    {16'h8555, 8'hAA, 2'd0, 3'b000},  // R2
    {16'h02AA, 8'h55, 2'd0, 3'b000},
    {16'h0555, 8'hA0, 2'd2, 3'b000},  // R4
    {16'h0000, 8'hF0, 2'd0, 3'b100},  // R10
    {16'h0555, 8'hAA, 2'd0, 3'b000},
    {16'h02AA, 8'h55, 2'd0, 3'b000},
    {16'h0555, 8'h80, 2'd0, 3'b000},
    {16'h0555, 8'hAA, 2'd0, 3'b000},
    {16'h02AA, 8'h55, 2'd0, 3'b000},
    {16'h0777, 8'h30, 2'd2, 3'b001},  // R5
    {16'h0999, 8'h30, 2'd2, 3'b000},  // R6
    {16'h0000, 8'hF0, 2'd2, 3'b000}   // R10
  };

  task automatic ck(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic unl(input logic [7:0] c);
    wr(16'h0555, 8'hAA);
    wr(16'h02AA, 8'h55);
    wr(16'h0555, c);
  endtask

  task automatic done_pulse;
    @(negedge clk);
    erase_done = 1'b1;
    @(negedge clk);
    erase_done = 1'b0;
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #2000000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    ck("R1 mode", rd_mode, 0);
    ck("R1 strobes", {prog_stb, chip_erase_stb, sect_erase_stb}, 0);

    for (int i = 0; i < 20; i++) begin
      wr(VEC[i][28:13], VEC[i][12:5]);
      ck($sformatf("R2..R10 vec%0d mode", i), rd_mode, VEC[i][4:3]);
      ck($sformatf("R2..R10 vec%0d strobes", i),
         {prog_stb, chip_erase_stb, sect_erase_stb}, VEC[i][2:0]);
    end
    done_pulse();
    ck("R6 erase_done", rd_mode, 0);

    // R2 wrong second unlock address
    wr(16'h0555, 8'hAA); wr(16'h02AB, 8'h55); wr(16'h0555, 8'h90);
    ck("R2 mismatch", rd_mode, 0);

    // R4 program data and address
    unl(8'hA0);
    wr(16'h0ABC, 8'hF5);
    ck("R4 stb", prog_stb, 1);
    ck("R4 addr", prog_addr, 16'h0ABC);
    ck("R4 data", prog_data, 8'h34);
    ck("R4 mode", rd_mode, 0);
    @(negedge clk);
    ck("R11 one cycle", prog_stb, 0);

    // R5 chip erase
    unl(8'h80); wr(16'h0555, 8'hAA); wr(16'h02AA, 8'h55); wr(16'h0555, 8'h10);
    ck("R5 chip stb", chip_erase_stb, 1);
    ck("R5 chip mode", rd_mode, 2);
    wr(16'h0000, 8'h30);
    ck("R6 chip ignores", {rd_mode, sect_erase_stb}, 3'b100);
    done_pulse();
    ck("R5 chip done", rd_mode, 0);

    // R5 0x10 at wrong address
    unl(8'h80); wr(16'h0555, 8'hAA); wr(16'h02AA, 8'h55); wr(16'h0444, 8'h10);
    ck("R5 bad chip", {rd_mode, chip_erase_stb}, 3'b000);

    // R6 multi-sector
    unl(8'h80); wr(16'h0555, 8'hAA); wr(16'h02AA, 8'h55); wr(16'h1000, 8'h30);
    ck("R5 sect addr", sect_addr, 16'h1000);
    erase_open = 1'b1;
    wr(16'h2000, 8'h30);
    ck("R6 second stb", sect_erase_stb, 1);
    ck("R6 second addr", sect_addr, 16'h2000);
    wr(16'h0000, 8'h00);
    ck("R6 other aborts", rd_mode, 0);
    erase_open = 1'b0;

    // R7 bypass
    unl(8'h20);
    ck("R7 enter", rd_mode, 0);
    wr(16'h1234, 8'hA0);
    ck("R7 no unlock", rd_mode, 2);
    wr(16'h0040, 8'h0F);
    ck("R7 prog", prog_stb, 1);
    wr(16'h7777, 8'hA0);
    ck("R7 stays bypass", rd_mode, 2);
    wr(16'h0041, 8'hFF);
    wr(16'h3333, 8'h90);
    ck("R7 autoselect", rd_mode, 1);
    wr(16'h0000, 8'h00);
    ck("R7 exit", rd_mode, 0);
    wr(16'h1234, 8'hA0);
    ck("R7 left bypass", rd_mode, 0);

    // R3 ID words
    unl(8'h90);
    rd_idx = 8'h00; #1 ck("R3 id0", id_q, 16'h0001);
    rd_idx = 8'h01; #1 ck("R3 id1", id_q, 16'h227E);
    rd_idx = 8'h02; #1 ck("R3 prot", id_q, 16'h0000);
    rd_idx = 8'h0E; #1 ck("R3 id2", id_q, 16'h2210);
    rd_idx = 8'h0F; #1 ck("R3 id3 ff", id_q, 16'h5A3C);
    rd_idx = 8'h07; #1 ck("R3 other", id_q, 16'h5A3C);
    wr(16'h0000, 8'hF0);
    ck("R10 from auto", rd_mode, 0);

    summary();
  end
endmodule